// File: doc/BRIEF.md
# Selectable clock gate controller

This block controls the enable of a single clock gate. It has one 32-bit control and status word. A select bit in that word hands the gate to one of two controllers. In hardware mode, a request input opens the gate automatically. In software mode, an enable bit in the word opens and closes it. Opening is immediate. In hardware mode, an optional hysteresis can keep the gate open for a short or a long idle window after the request drops. This avoids rapid toggling when the requests come in bursts.

The enable output is registered. It is meant to drive a latch-based gate cell, modelled here as a plain enable. A read-only status bit follows the enable after a fixed settling delay, so software can poll it to confirm that a change has completed. A build parameter picks the gate kind:
- selectable, where both controllers are available;
- forced, where the gate is held open whenever software owns it;
- none, where no gate logic is built and the clock is always enabled.

Top module: `clk_gate_ctl`

## Requirements
- R1: After reset, clk_en is 1, gate_status is 1 and reg_rd_data reads 0x0000_0103.
- R2: The control word has these fields: bit 0 software enable, bit 1 select (1 = software, 0 = hardware), bit 2 hysteresis on, bit 3 long delay, bit 8 status. Bit 8 is read-only. Every other bit reads 0 and ignores writes.
- R3: In software mode, clk_en equals the software enable bit. A write takes effect on the clock edge after the edge that stores it. hw_req has no effect in this mode.
- R4: In hardware mode, clk_en rises on the first clock edge that samples hw_req high.
- R5: In hardware mode with hysteresis off, clk_en falls on the first clock edge that samples hw_req low.
- R6: In hardware mode with hysteresis on and the long bit 0, clk_en stays high for 4 further edges after the first edge that samples hw_req low, then falls.
- R7: In hardware mode with hysteresis on and the long bit 1, the hold lasts 16 edges.
- R8: gate_status equals clk_en delayed by 2 clock edges, and it reads back in bit 8.
- R9: A change of the select bit changes clk_en once, on the edge after the write, with no intermediate toggle.
- R10: In hardware mode, the software enable bit has no effect on clk_en.
- R11: Forced kind: in software mode clk_en is 1 whatever the enable bit. In hardware mode it behaves as in R4 to R7.
- R12: None kind: clk_en is 1 under every register setting and hw_req pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 1 | Hardware request to run the clock |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Control word with status in bit 8 |
| clk_en | output | 1 | Registered gate enable |
| gate_status | output | 1 | Settled gate state |

## Verification
The bench builds three instances, one per gate kind, with the default delays of 4 and 16 cycles and a settling depth of 2. All three run from the same stimulus, so one sequence covers the forced and absent variants alongside the selectable one. The short default windows make it possible to walk each hysteresis hold edge by edge and to see the exact edge on which it closes. They also make it possible to see the two-edge status lag after every transition.

// File: rtl/cgc_pkg.sv
package cgc_pkg;

  typedef enum logic [1:0] {
    GK_NONE   = 2'd0,
    GK_SELECT = 2'd1,
    GK_FORCED = 2'd2
  } gate_kind_e;

  typedef struct packed {
    logic hyst_long;
    logic hyst_en;
    logic sw_sel;
    logic sw_en;
  } ctrl_t;

  localparam int CTRL_BITS  = 4;
  localparam int STATUS_POS = 8;
  localparam logic [CTRL_BITS-1:0] CTRL_RESET = 4'b0011;

  function automatic ctrl_t decode_ctrl(input logic [31:0] word);
    return ctrl_t'(word[CTRL_BITS-1:0]);
  endfunction

  function automatic logic [31:0] build_word(input ctrl_t c, input logic status);
    logic [31:0] w;
    w = '0;
    w[CTRL_BITS-1:0] = c;
    w[STATUS_POS] = status;
    return w;
  endfunction

  function automatic int hold_cycles(input logic long_sel, input int short_d, input int long_d);
    return long_sel ? long_d : short_d;
  endfunction

endpackage

// File: rtl/cgc_ctrl_reg.sv
module cgc_ctrl_reg
  import cgc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output ctrl_t       ctrl
);
  logic unused_hi;
  assign unused_hi = ^wr_data[31:CTRL_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl <= ctrl_t'(CTRL_RESET);
    else if (wr_en) ctrl <= decode_ctrl(wr_data);
  end
endmodule

// File: rtl/cgc_hyst.sv
module cgc_hyst #(
  parameter int SHORT_DLY = 4,
  parameter int LONG_DLY  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_req,
  input  logic hyst_long,
  output logic hold
);
  localparam int MAXD = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
  localparam int CW   = $clog2(MAXD + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;

  assign load_val = CW'(cgc_pkg::hold_cycles(hyst_long, SHORT_DLY, LONG_DLY));

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (hw_req)      cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign hold = (cnt != '0);
endmodule

// File: rtl/cgc_settle.sv
module cgc_settle #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= RST_VAL;
        else        pipe <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/clk_gate_ctl.sv
module clk_gate_ctl
  import cgc_pkg::*;
#(
  parameter gate_kind_e GATE_KIND     = GK_SELECT,
  parameter int         SHORT_DLY     = 4,
  parameter int         LONG_DLY      = 16,
  parameter int         SETTLE_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hw_req,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wr_data,
  output logic [31:0] reg_rd_data,
  output logic        clk_en,
  output logic        gate_status
);
  ctrl_t ctrl;
  logic  sw_sel_w, sw_en_w, hyst_en_w, hyst_long_w;
  logic  hold, hw_open, en_next;

  cgc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data), .ctrl(ctrl)
  );

  assign sw_sel_w    = ctrl.sw_sel;
  assign sw_en_w     = ctrl.sw_en;
  assign hyst_en_w   = ctrl.hyst_en;
  assign hyst_long_w = ctrl.hyst_long;

  cgc_hyst #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_hyst (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hyst_long(hyst_long_w), .hold(hold)
  );

  assign hw_open = hw_req | (hyst_en_w & hold);

  generate
    if (GATE_KIND == GK_NONE) begin : g_none
      assign en_next = 1'b1;
    end else if (GATE_KIND == GK_FORCED) begin : g_forced
      assign en_next = sw_sel_w ? 1'b1 : hw_open;
    end else begin : g_select
      assign en_next = sw_sel_w ? sw_en_w : hw_open;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) clk_en <= 1'b1;
    else        clk_en <= en_next;
  end

  cgc_settle #(.STAGES(SETTLE_CYCLES), .RST_VAL(1'b1)) u_settle (
    .clk(clk), .rst_n(rst_n), .d(clk_en), .q(gate_status)
  );

  assign reg_rd_data = build_word(ctrl, gate_status);
endmodule

// File: rtl/cgc_checker.sv
module cgc_checker
  import cgc_pkg::*;
#(
  parameter gate_kind_e KIND   = GK_SELECT,
  parameter int         SETTLE = 2
) (
  input logic clk,
  input logic rst_n,
  input logic hw_req,
  input logic sw_sel,
  input logic sw_en,
  input logic hyst_en,
  input logic hold,
  input logic clk_en,
  input logic gate_status
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  p_hw_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_sel && hw_req) |=> clk_en);

  p_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND != GK_NONE && !sw_sel && !hw_req && !(hyst_en && hold)) |=> !clk_en);

  p_hold_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_sel && hyst_en && hold) |=> clk_en);

  p_sw_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == GK_SELECT && sw_sel) |=> (clk_en == $past(sw_en)));

  p_forced_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == GK_FORCED && sw_sel) |=> clk_en);

  generate
    if (SETTLE == 2) begin : g_settle
      p_status_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (gate_status == $past(clk_en, 2)));
    end
  endgenerate
endmodule

bind clk_gate_ctl cgc_checker #(.KIND(GATE_KIND), .SETTLE(SETTLE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_sel(sw_sel_w), .sw_en(sw_en_w),
  .hyst_en(hyst_en_w), .hold(hold), .clk_en(clk_en), .gate_status(gate_status)
);

// File: tb/sim_clk_gate_ctl.sv
module sim_clk_gate_ctl;
  import cgc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_req = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [2:0] en_w, st_w;
  logic [31:0] rd_w [3];

  always #4 clk = ~clk;

  clk_gate_ctl #(.GATE_KIND(GK_SELECT)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(rd_w[0]), .clk_en(en_w[0]), .gate_status(st_w[0]));
  clk_gate_ctl #(.GATE_KIND(GK_FORCED)) u1 (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(rd_w[1]), .clk_en(en_w[1]), .gate_status(st_w[1]));
  clk_gate_ctl #(.GATE_KIND(GK_NONE)) u2 (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(rd_w[2]), .clk_en(en_w[2]), .gate_status(st_w[2]));

  typedef struct {
    logic [2:0] en;
    logic [2:0] st;
    logic [3:0] ctl;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state: index 0 selectable, 1 forced, 2 none
  logic [2:0] m_en = 3'b111, m_p1 = 3'b111, m_st = 3'b111;
  logic [3:0] m_ctl = 4'b0011;
  int idle = 1000;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic hw, input logic wr, input logic [31:0] d, input string tag);
    exp_t e;
    logic opened;
    int win;
    @(negedge clk);
    hw_req = hw; reg_wr_en = wr; reg_wr_data = d;
    win = m_ctl[3] ? 16 : 4;
    opened = hw || (m_ctl[2] && idle < win);
    for (int k = 0; k < 3; k++) begin
      logic nxt;
      if (k == 2)          nxt = 1'b1;
      else if (m_ctl[1])   nxt = (k == 1) ? 1'b1 : m_ctl[0];
      else                 nxt = opened;
      m_st[k] = m_p1[k];
      m_p1[k] = m_en[k];
      m_en[k] = nxt;
    end
    idle = hw ? 0 : ((idle < 1000) ? idle + 1 : idle);
    if (wr) m_ctl = d[3:0];
    e.en = m_en; e.st = m_st; e.ctl = m_ctl; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pops one expectation per edge, sampling 2 ns after it
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      for (int k = 0; k < 3; k++) begin
        string t;
        logic [31:0] exp_rd;
        t = (k == 0) ? e.tag : ((k == 1) ? "R11" : "R12");
        exp_rd = {23'b0, e.st[k], 4'b0, e.ctl};
        check(en_w[k] == e.en[k], t, {31'b0, en_w[k]}, {31'b0, e.en[k]});
        check(st_w[k] == e.st[k], "R8", {31'b0, st_w[k]}, {31'b0, e.st[k]});
        check(rd_w[k] == exp_rd, "R2", rd_w[k], exp_rd);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(en_w == 3'b111, "R1", {29'b0, en_w}, 32'h7);
    check(st_w == 3'b111, "R1", {29'b0, st_w}, 32'h7);
    check(rd_w[0] == 32'h103, "R1", rd_w[0], 32'h103);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step(0, 0, 0, "R1");
    // field layout, read-only status, upper bits ignored
    step(0, 1, 32'hFFFF_FFF0, "R2");
    repeat (20) step(0, 0, 0, "R7");
    step(0, 1, 32'h0000_0103, "R2");
    repeat (3) step(0, 0, 0, "R2");
    // software mode, hw_req ignored
    step(0, 1, 32'h2, "R3");
    repeat (3) step(0, 0, 0, "R3");
    repeat (3) step(1, 0, 0, "R3");
    step(1, 1, 32'h3, "R3");
    repeat (3) step(0, 0, 0, "R3");
    // hardware mode without hysteresis
    step(0, 1, 32'h0, "R9");
    repeat (3) step(0, 0, 0, "R5");
    repeat (2) step(1, 0, 0, "R4");
    repeat (3) step(0, 0, 0, "R5");
    step(1, 0, 0, "R4");
    step(0, 0, 0, "R5");
    // software enable ignored in hardware mode
    step(0, 1, 32'h1, "R10");
    repeat (4) step(0, 0, 0, "R10");
    // short hold
    step(0, 1, 32'h4, "R6");
    repeat (3) step(1, 0, 0, "R4");
    repeat (8) step(0, 0, 0, "R6");
    repeat (2) step(1, 0, 0, "R6");
    step(0, 0, 0, "R6");
    step(1, 0, 0, "R6");
    repeat (8) step(0, 0, 0, "R6");
    // long hold
    step(0, 1, 32'hC, "R7");
    repeat (2) step(1, 0, 0, "R7");
    repeat (20) step(0, 0, 0, "R7");
    // select switch while closed and while open
    step(0, 1, 32'h3, "R9");
    repeat (3) step(0, 0, 0, "R9");
    step(0, 1, 32'h0, "R9");
    repeat (3) step(0, 0, 0, "R9");
    step(1, 1, 32'h2, "R9");
    repeat (3) step(1, 0, 0, "R9");
    step(0, 0, 0, "R9");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule